// File: doc/BRIEF.md
# Prioritized Interrupt Event Controller

This block collects four one-cycle event pulses from a peripheral (a health test failure, a rejected command, a finished command and a ready capture word) into sticky raw flags. A per-bit enable mask selects which flags can raise the single interrupt request line. Software can read the raw flags and the masked flags. It can force flags on or off with write-one strobe registers.

An index register names the most urgent enabled pending event as a small number. A CPU read of that register also acknowledges the event it reports, so an interrupt handler can service events one at a time by reading the index until it returns zero. A read that carries the debug qualifier sees the same values but changes no flag. Reading the captured data word, which the block passes through from its `cap_data` input, also acknowledges the capture-ready flag.

The register port is a plain single-cycle access port. Read data is combinational from the current state. Any state change caused by an access appears from the next cycle.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After a synchronous reset all raw flags and all mask bits are 0, the index reads 0 and `irq` is low.
- R2: A pulse on `evt_pulse[i]` sets raw flag i, visible from the next cycle. Bit 0 is health fail, bit 1 is command rejected, bit 2 is command done and bit 3 is capture ready.
- R3: The mask register is read and written at address 0, the raw flags read at address 1, and the masked flags read at address 2. The masked flags equal raw AND mask, and `irq` is high exactly when any masked flag is set.
- R4: The index, read at address 5, is 0 when no masked flag is set. Otherwise it is one plus the position of the lowest-numbered set masked flag, so bit 0 wins.
- R5: A CPU read (`bus_dbg` low) of the index clears only the raw flag it reported, from the next cycle. The index then shows the next pending event, or 0.
- R6: A read with `bus_dbg` high, of the index or of the capture word, clears no flag.
- R7: Writing address 3 sets every raw flag whose data bit is 1. Bits written 0 are left as they were.
- R8: Writing address 4 clears every raw flag whose data bit is 1, whatever the mask. Bits written 0 are left as they were.
- R9: A read of address 6 returns `cap_data`. When it is a CPU read, it clears the capture-ready flag (bit 3).
- R10: When an event pulse and a clear (strobe, index acknowledge or capture read) hit the same flag in one cycle, the flag ends set.
- R11: Flags whose mask bit is 0 are never reported by the index and are never cleared by an index read.
- R12: Reads of unmapped addresses (7) and of the write-only addresses 3 and 4 return 0. Writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | Event pulses, one bit per event source |
| cap_data | input | 32 | Captured data word returned by a read of address 6 |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_dbg | input | 1 | Read comes from the debug path; suppresses read side effects |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Interrupt request, high while any masked flag is set |

## Verification
Read data and `irq` follow the register state in the same cycle, with no added latency. Every flag or mask change caused by an event, a strobe write or a side-effecting read is due one clock edge after the cycle that carries it. The bench drives each stimulus after a falling edge. Shortly after that it compares `bus_rdata` and `irq` against a behavioural model holding the state from before the coming rising edge, then applies the same stimulus to the model at that edge. Each effect is therefore expected exactly one access later, and every cycle is compared.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    localparam int EVT_N  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = $clog2(EVT_N + 1);

    localparam int BIT_HEALTH  = 0;
    localparam int BIT_REJECT  = 1;
    localparam int BIT_DONE    = 2;
    localparam int BIT_CAPTURE = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK    = 3'd0,
        A_RAW     = 3'd1,
        A_MSTAT   = 3'd2,
        A_SET     = 3'd3,
        A_CLR     = 3'd4,
        A_INDEX   = 3'd5,
        A_CAPDATA = 3'd6,
        A_NONE    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             mask_we;
        logic [EVT_N-1:0] mask_wd;
        logic [EVT_N-1:0] set_vec;
        logic [EVT_N-1:0] clr_vec;
        logic             idx_ack;
        logic             cap_ack;
    } flag_ctl_t;

    function automatic logic [EVT_N-1:0] idx_to_onehot(input logic [IDX_W-1:0] idx);
        logic [EVT_N-1:0] v;
        v = '0;
        for (int i = 0; i < EVT_N; i++) begin
            if (idx == IDX_W'(i + 1)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_evt_pkg::*;
#(
    parameter int N = EVT_N,
    parameter int W = DATA_W
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_dbg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [N-1:0]      raw_q,
    input  logic [N-1:0]      mask_q,
    input  logic [IDX_W-1:0]  idx,
    input  logic [W-1:0]      cap_data,
    output flag_ctl_t         ctl,
    output logic [W-1:0]      bus_rdata
);

    localparam int PAD_IDX = W - IDX_W;
    localparam int PAD_EVT = W - N;

    logic      wr_cyc;
    logic      rd_cyc;
    logic      rd_cpu;
    reg_addr_e addr;
    logic      unused_wdata_hi;

    assign addr            = reg_addr_e'(bus_addr);
    assign wr_cyc          = bus_sel & bus_wr;
    assign rd_cyc          = bus_sel & ~bus_wr;
    assign rd_cpu          = rd_cyc & ~bus_dbg;
    assign unused_wdata_hi = ^bus_wdata[W-1:N];

    always_comb begin
        ctl         = '0;
        ctl.mask_wd = bus_wdata[N-1:0];
        if (wr_cyc) begin
            unique case (addr)
                A_MASK:  ctl.mask_we = 1'b1;
                A_SET:   ctl.set_vec = bus_wdata[N-1:0];
                A_CLR:   ctl.clr_vec = bus_wdata[N-1:0];
                default: ;
            endcase
        end
        if (rd_cpu) begin
            ctl.idx_ack = (addr == A_INDEX);
            ctl.cap_ack = (addr == A_CAPDATA);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            unique case (addr)
                A_MASK:    bus_rdata = {{PAD_EVT{1'b0}}, mask_q};
                A_RAW:     bus_rdata = {{PAD_EVT{1'b0}}, raw_q};
                A_MSTAT:   bus_rdata = {{PAD_EVT{1'b0}}, raw_q & mask_q};
                A_INDEX:   bus_rdata = {{PAD_IDX{1'b0}}, idx};
                A_CAPDATA: bus_rdata = cap_data;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_evt_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic [N-1:0]     pend,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     win
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign win[i]      = pend[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | pend[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            idx = idx | (win[i] ? IDX_W'(i + 1) : '0);
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_evt_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] mask_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[i] <= 1'b0;
            end else if (evt[i] | set_vec[i]) begin
                raw_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                raw_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wd;
        end
    end

endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
    import irq_evt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic [W-1:0]      cap_data,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_dbg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);

    flag_ctl_t        ctl;
    logic [EVT_N-1:0] raw_q;
    logic [EVT_N-1:0] mask_q;
    logic [EVT_N-1:0] pend;
    logic [EVT_N-1:0] win;
    logic [IDX_W-1:0] idx;
    logic [EVT_N-1:0] clr_all;
    logic [EVT_N-1:0] cap_bit;

    assign pend    = raw_q & mask_q;
    assign cap_bit = EVT_N'(1) << BIT_CAPTURE;
    assign clr_all = ctl.clr_vec
                   | (ctl.idx_ack ? win : '0)
                   | (ctl.cap_ack ? cap_bit : '0);
    assign irq     = |pend;

    irq_reg_port #(.N(EVT_N), .W(W)) u_port (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_dbg   (bus_dbg),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw_q     (raw_q),
        .mask_q    (mask_q),
        .idx       (idx),
        .cap_data  (cap_data),
        .ctl       (ctl),
        .bus_rdata (bus_rdata)
    );

    irq_prio_enc #(.N(EVT_N)) u_enc (
        .pend (pend),
        .idx  (idx),
        .win  (win)
    );

    irq_flag_bank #(.N(EVT_N)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_pulse),
        .set_vec (ctl.set_vec),
        .clr_vec (clr_all),
        .mask_we (ctl.mask_we),
        .mask_wd (ctl.mask_wd),
        .raw_q   (raw_q),
        .mask_q  (mask_q)
    );

endmodule

// File: rtl/irq_evt_chk.sv
module irq_evt_chk
    import irq_evt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [EVT_N-1:0]  evt_pulse,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_dbg,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [EVT_N-1:0]  wd_lo,
    input logic [EVT_N-1:0]  raw_q,
    input logic [EVT_N-1:0]  mask_q,
    input logic [IDX_W-1:0]  idx,
    input logic              irq
);

    logic [EVT_N-1:0] rep_vec;
    logic             rd_idx_cpu;
    logic             rd_dbg;
    logic             wr_set;

    assign rep_vec    = idx_to_onehot(idx);
    assign rd_idx_cpu = bus_sel && !bus_wr && !bus_dbg && (bus_addr == A_INDEX);
    assign rd_dbg     = bus_sel && !bus_wr && bus_dbg;
    assign wr_set     = bus_sel && bus_wr && (bus_addr == A_SET);

    // R3 / R4: request line agrees with the encoder result
    assert_irq_matches_index_R4: assert property (@(posedge clk) disable iff (rst)
        irq == (idx != '0));

    // R11: a reported event is raw-pending and enabled
    assert_index_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        (idx != '0) |-> ((raw_q & mask_q & rep_vec) == rep_vec));

    // R4: nothing of higher priority is pending below the reported bit
    assert_index_lowest_R4: assert property (@(posedge clk) disable iff (rst)
        (idx != '0) |-> ((raw_q & mask_q & (rep_vec - EVT_N'(1))) == '0));

    // R5: CPU index read drops the reported flag unless an event re-sets it
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_cpu && idx != '0) |=> ((raw_q & $past(rep_vec & ~evt_pulse)) == '0));

    // R6: debug reads only ever let flags grow
    assert_dbg_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
        rd_dbg |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R7: set strobe raises every written-one bit
    assert_set_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((raw_q & $past(wd_lo)) == $past(wd_lo)));

    // R10: an event pulse always leaves its flag set
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

endmodule

bind irq_evt_ctrl irq_evt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_dbg   (bus_dbg),
    .bus_addr  (bus_addr),
    .wd_lo     (bus_wdata[irq_evt_pkg::EVT_N-1:0]),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .idx       (idx),
    .irq       (irq)
);

// File: tb/sim_irq_evt_ctrl.sv
module sim_irq_evt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] evt_pulse = '0;
    logic [DW-1:0] cap_data = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_dbg = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int m_raw  = 0;
    int m_mask = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_evt_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .cap_data  (cap_data),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_dbg   (bus_dbg),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int model_index();
        int p;
        p = m_raw & m_mask;
        for (int i = 0; i < NE; i++) begin
            if (p[i]) return i + 1;
        end
        return 0;
    endfunction

    function automatic int model_rdata(input int addr, input int cap);
        case (addr)
            0: return m_mask;
            1: return m_raw;
            2: return m_raw & m_mask;
            5: return model_index();
            6: return cap;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One access cycle: drive, compare against the model, then advance the model at the edge.
    task automatic step(input string tag, input bit sel, input bit wr, input bit dbg,
                        input int addr, input int wdata, input int evt, input int cap);
        int exp_rd;
        int clr;
        int st;
        @(negedge clk);
        bus_sel   = sel;
        bus_wr    = wr;
        bus_dbg   = dbg;
        bus_addr  = addr[2:0];
        bus_wdata = wdata;
        evt_pulse = evt[NE-1:0];
        cap_data  = cap;
        #1;
        exp_rd = (sel && !wr) ? model_rdata(addr, cap) : 0;
        compare(tag, int'(bus_rdata), exp_rd, "rdata");
        compare(tag, int'(irq), ((m_raw & m_mask) != 0) ? 1 : 0, "irq");
        clr = 0;
        st  = 0;
        if (sel && wr && addr == 0) m_mask = wdata & 15;
        if (sel && wr && addr == 3) st = wdata & 15;
        if (sel && wr && addr == 4) clr = wdata & 15;
        if (sel && !wr && !dbg && addr == 5 && model_index() != 0) clr = clr | (1 << (model_index() - 1));
        if (sel && !wr && !dbg && addr == 6) clr = clr | 8;
        @(posedge clk);
        m_raw = ((m_raw & ~clr) | st | evt) & 15;
    endtask

    task automatic rd(input string tag, input int addr);
        step(tag, 1'b1, 1'b0, 1'b0, addr, 0, 0, 0);
    endtask

    task automatic wr(input string tag, input int addr, input int data);
        step(tag, 1'b1, 1'b1, 1'b0, addr, data, 0, 0);
    endtask

    task automatic ev(input string tag, input int evt);
        step(tag, 1'b0, 1'b0, 1'b0, 0, 0, evt, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd("R1", 1); rd("R1", 0); rd("R1", 5); ev("R1", 0);
        // R2 / R3: events set raw, masked view follows mask
        ev("R2", 4'b0100);
        rd("R2", 1); rd("R3", 2);
        wr("R3", 0, 32'hFFFF_FFFF);
        rd("R3", 0); rd("R3", 2);
        ev("R2", 4'b1001);
        rd("R2", 1);
        // R4 / R5: walk the index in priority order
        rd("R4", 5); rd("R5", 5); rd("R5", 5); rd("R5", 5); rd("R5", 1);
        // R6: debug reads leave flags alone
        wr("R7", 3, 4'b1111);
        step("R6", 1, 0, 1, 5, 0, 0, 32'h1234_5678);
        step("R6", 1, 0, 1, 6, 0, 0, 32'hCAFE_F00D);
        rd("R6", 1);
        // R9: capture read returns data and clears bit 3
        step("R9", 1, 0, 0, 6, 0, 0, 32'hA5A5_0F0F);
        rd("R9", 1);
        // R7 / R8: write-one strobes, zeros ignored, clear regardless of mask
        wr("R8", 4, 4'b1111);
        wr("R7", 3, 0); rd("R7", 1);
        wr("R7", 3, 4'b0101); rd("R7", 1);
        wr("R8", 0, 0);
        wr("R8", 4, 0); rd("R8", 1);
        wr("R8", 4, 4'b0001); rd("R8", 1);
        // R11: masked flags never reported nor acknowledged
        wr("R11", 3, 4'b1111);
        rd("R11", 5); rd("R11", 5); rd("R11", 1);
        wr("R11", 0, 4'b1010);
        rd("R11", 5); rd("R11", 5); rd("R11", 1); rd("R11", 5); rd("R11", 5); rd("R11", 1);
        // R10: event beats clear strobe, index ack and capture ack
        wr("R10", 0, 4'b1111);
        wr("R10", 3, 4'b1111);
        step("R10", 1, 1, 0, 4, 4'b0011, 4'b0010, 0);
        rd("R10", 1);
        step("R10", 1, 0, 0, 5, 0, 4'b0001, 0);
        rd("R10", 1);
        step("R10", 1, 0, 0, 6, 0, 4'b1000, 32'h0000_0077);
        rd("R10", 1);
        // R12: unmapped and write-only reads are zero, writes to read-only ignored
        rd("R12", 7); rd("R12", 3); rd("R12", 4);
        wr("R12", 1, 0); wr("R12", 2, 0); wr("R12", 5, 0); wr("R12", 7, 4'b1111);
        rd("R12", 1); rd("R12", 0);
        // drain and reset again
        rd("R5", 5); rd("R5", 5); rd("R5", 5);
        @(negedge clk);
        rst = 1'b1;
        bus_sel = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_raw = 0;
        m_mask = 0;
        rd("R1", 1); rd("R1", 0); ev("R1", 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule